// File: doc/BRIEF.md
# Programmable Parallel Write Strobe Generator

This block drives a write-only parallel port that has a 16-bit data bus and no address lines, such as the parallel configuration input of a programmable logic device. The receiver captures each word on the rising edge of an active-low write strobe. A host hands words to the block over a valid/ready handshake. Each accepted word starts one write cycle. In that cycle a counter advances on every functional clock, beginning at count 0 and stopping at a programmed last count.

Each port transition happens at a programmed count. Chip select and the write strobe each have a falling count and a rising count. The new word appears on the bus at a data-on count. The cycle finishes at the last count. Because there is no address phase, the strobe may fall at count 0 with data already on the bus, and the strobe low pulse can be one clock long.

Timing values are loaded into a shadow set and checked against an ordering rule. A set that breaks the rule is dropped. The active timing is copied from the shadow set when a write cycle starts, so a cycle never changes its timing partway through. If another word is waiting at the last count, the next cycle follows on the next clock with no gap.

Top module: `strobe_writer`

## Requirements
- R1: After reset, `port_cs_n` and `port_we_n` are 1, `port_data` is 0 and `in_ready` is 1. The active and shadow timing are cs_on=0, cs_off=3, data_on=0, we_on=1, we_off=3, last=4.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Count 0 of its write cycle is the clock period that follows that edge.
- R3: During counts c with cs_on <= c < cs_off, `port_cs_n` is 0. At every other count of the cycle it is 1. Chip select is therefore low in the period just before the strobe rises.
- R4: During counts c with we_on <= c < we_off, `port_we_n` is 0. At every other count it is 1. A pulse one count long (we_off = we_on + 1) is allowed.
- R5: At counts below data_on, `port_data` still shows the word of the previous cycle. From data_on through the last count it shows the new word. It does not change while the strobe is low, nor in the period in which the strobe rises.
- R6: During a cycle, `in_ready` is 1 only at the last count.
- R7: If a word is waiting at the last count, the next cycle's count 0 follows on the next clock. N back-to-back words therefore take exactly N*(last+1) clocks.
- R8: While idle, `port_cs_n` and `port_we_n` stay 1 and `port_data` keeps the last word sent.
- R9: A timing set loaded with `cfg_load` is kept only if all of the following hold: data_on <= we_on, cs_on <= we_on, we_on < we_off, we_off <= cs_off, cs_off <= last, and we_off < last. Any other set is ignored, and the previous valid set stays in force.
- R10: A set with data_on = we_on = cs_on = 0 is valid, so the strobe falls at count 0. A set that is kept is used from the next cycle that starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host word valid |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | Block can take a word this clock |
| cfg_load | input | 1 | Load the timing set on the cfg inputs into the shadow set |
| cfg_cs_on | input | 6 | Count at which chip select falls |
| cfg_cs_off | input | 6 | Count at which chip select rises |
| cfg_data_on | input | 6 | Count from which the new word is on the bus |
| cfg_we_on | input | 6 | Count at which the write strobe falls |
| cfg_we_off | input | 6 | Count at which the write strobe rises (capture edge) |
| cfg_last | input | 6 | Last count of the write cycle |
| port_cs_n | output | 1 | Active-low chip select |
| port_we_n | output | 1 | Active-low write strobe |
| port_data | output | 16 | Data bus |

## Verification
The assertions assume the host holds `in_data` steady while `in_valid` is high and no acceptance has happened yet. They also assume reset is held for at least one clock before any traffic. The bench drives every input on the falling clock edge and changes the word only after an acceptance, which keeps it within these assumptions. The assertion on the timing ordering takes no assumption about the `cfg_*` inputs: the bench loads sets that break the ordering on purpose, and the filter must drop them before they reach the active set.

// File: rtl/wstrb_pkg.sv
package wstrb_pkg;

  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t cs_on;
    cnt_t cs_off;
    cnt_t data_on;
    cnt_t we_on;
    cnt_t we_off;
    cnt_t last;
  } wtime_t;

  localparam wtime_t WTIME_RST = '{
    cs_on:   cnt_t'(0),
    cs_off:  cnt_t'(3),
    data_on: cnt_t'(0),
    we_on:   cnt_t'(1),
    we_off:  cnt_t'(3),
    last:    cnt_t'(4)
  };

  // Ordering rule for a usable timing set.
  function automatic logic wtime_ok(wtime_t t);
    logic early, pulse, tail;
    early = (t.data_on <= t.we_on) && (t.cs_on <= t.we_on);
    pulse = (t.we_on < t.we_off);
    tail  = (t.we_off <= t.cs_off) && (t.cs_off <= t.last) && (t.we_off < t.last);
    return early && pulse && tail;
  endfunction

  // True when count c lies in the half-open range [lo, hi).
  function automatic logic in_window(cnt_t c, cnt_t lo, cnt_t hi);
    return (c >= lo) && (c < hi);
  endfunction

endpackage

// File: rtl/wstrb_cfg.sv
module wstrb_cfg
  import wstrb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  wtime_t cand,
  input  logic   cyc_start,
  output wtime_t active
);

  wtime_t shadow;
  logic   cand_ok;

  assign cand_ok = wtime_ok(cand);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= WTIME_RST;
      active <= WTIME_RST;
    end else begin
      if (load && cand_ok) shadow <= cand;
      if (cyc_start)       active <= shadow;
    end
  end

  // R9
  active_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wtime_ok(active));

  // R10
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(active));

endmodule

// File: rtl/wstrb_seq.sv
module wstrb_seq
  import wstrb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  cnt_t          last,
  output logic          in_ready,
  output logic          cyc_start,
  output logic          cyc_last,
  output logic          busy,
  output cnt_t          cnt,
  output logic [DW-1:0] word_q,
  output logic [DW-1:0] prev_q
);

  assign cyc_last  = busy && (cnt == last);
  assign in_ready  = !busy || cyc_last;
  assign cyc_start = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
      prev_q <= '0;
    end else begin
      if (cyc_last) prev_q <= word_q;
      if (cyc_start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        word_q <= in_data;
      end else if (cyc_last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (busy && cnt == '0 && word_q == $past(in_data)));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= last));

endmodule

// File: rtl/wstrb_decode.sv
module wstrb_decode
  import wstrb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          busy,
  input  cnt_t          cnt,
  input  wtime_t        t,
  input  logic [DW-1:0] word_q,
  input  logic [DW-1:0] prev_q,
  output logic          cs_n,
  output logic          we_n,
  output logic [DW-1:0] data
);

  logic cs_act, we_act, data_new;

  always_comb begin
    cs_act   = busy && in_window(cnt, t.cs_on, t.cs_off);
    we_act   = busy && in_window(cnt, t.we_on, t.we_off);
    data_new = busy && (cnt >= t.data_on);
    cs_n     = !cs_act;
    we_n     = !we_act;
    data     = data_new ? word_q : prev_q;
  end

endmodule

// File: rtl/strobe_writer.sv
module strobe_writer
  import wstrb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          cfg_load,
  input  logic [5:0]    cfg_cs_on,
  input  logic [5:0]    cfg_cs_off,
  input  logic [5:0]    cfg_data_on,
  input  logic [5:0]    cfg_we_on,
  input  logic [5:0]    cfg_we_off,
  input  logic [5:0]    cfg_last,
  output logic          port_cs_n,
  output logic          port_we_n,
  output logic [DW-1:0] port_data
);

  wtime_t          cand, active;
  logic            cyc_start, cyc_last, busy;
  cnt_t            cnt;
  logic [DW-1:0]   word_q, prev_q;

  assign cand = '{cs_on: cfg_cs_on, cs_off: cfg_cs_off, data_on: cfg_data_on,
                  we_on: cfg_we_on, we_off: cfg_we_off, last: cfg_last};

  wstrb_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .cand      (cand),
    .cyc_start (cyc_start),
    .active    (active)
  );

  wstrb_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .last      (active.last),
    .in_ready  (in_ready),
    .cyc_start (cyc_start),
    .cyc_last  (cyc_last),
    .busy      (busy),
    .cnt       (cnt),
    .word_q    (word_q),
    .prev_q    (prev_q)
  );

  wstrb_decode #(.DW(DW)) u_dec (
    .busy   (busy),
    .cnt    (cnt),
    .t      (active),
    .word_q (word_q),
    .prev_q (prev_q),
    .cs_n   (port_cs_n),
    .we_n   (port_we_n),
    .data   (port_data)
  );

  // R3
  cs_at_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_we_n) |-> $past(!port_cs_n));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_we_n |=> $stable(port_data));

  // R6
  ready_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && busy) |-> cyc_last);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (port_cs_n && port_we_n && $stable(port_data)));

endmodule

// File: tb/strobe_writer_test.sv
module strobe_writer_test;
  import wstrb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        cfg_load = 1'b0;
  logic [5:0]  cfg_cs_on = '0, cfg_cs_off = '0, cfg_data_on = '0;
  logic [5:0]  cfg_we_on = '0, cfg_we_off = '0, cfg_last = '0;
  logic        port_cs_n, port_we_n;
  logic [15:0] port_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] bus_prev = '0;
  wtime_t      cur;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  strobe_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_load(cfg_load), .cfg_cs_on(cfg_cs_on),
    .cfg_cs_off(cfg_cs_off), .cfg_data_on(cfg_data_on), .cfg_we_on(cfg_we_on),
    .cfg_we_off(cfg_we_off), .cfg_last(cfg_last), .port_cs_n(port_cs_n),
    .port_we_n(port_we_n), .port_data(port_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic wtime_t mk(int a, int b, int d, int e, int f, int g);
    wtime_t t;
    t.cs_on = cnt_t'(a); t.cs_off = cnt_t'(b); t.data_on = cnt_t'(d);
    t.we_on = cnt_t'(e); t.we_off = cnt_t'(f); t.last = cnt_t'(g);
    return t;
  endfunction

  // Bench restatement of the ordering rule of R9.
  function automatic bit rule_ok(wtime_t t);
    if (t.we_off <= t.we_on) return 0;
    if (t.data_on > t.we_on || t.cs_on > t.we_on) return 0;
    if (t.cs_off < t.we_off || t.last < t.cs_off) return 0;
    return t.last > t.we_off;
  endfunction

  task automatic load_cfg(input wtime_t t);
    cfg_cs_on = t.cs_on; cfg_cs_off = t.cs_off; cfg_data_on = t.data_on;
    cfg_we_on = t.we_on; cfg_we_off = t.we_off; cfg_last = t.last;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    if (rule_ok(t)) cur = t;
  endtask

  // Entered at the negedge of count 0; leaves at the negedge after the last count.
  task automatic watch(input logic [15:0] w, input bit more, input logic [15:0] nxt);
    wtime_t t = cur;
    in_valid = more;
    in_data  = nxt;
    for (int c = 0; c <= int'(t.last); c++) begin
      bit cs_exp = !(c >= int'(t.cs_on) && c < int'(t.cs_off));
      bit we_exp = !(c >= int'(t.we_on) && c < int'(t.we_off));
      logic [15:0] d_exp = (c >= int'(t.data_on)) ? w : bus_prev;
      if (c == 0) check(in_ready == 1'b0, "R2", "ready at count 0", in_ready, 0);
      check(port_cs_n == cs_exp, "R3", $sformatf("cs_n count %0d", c), port_cs_n, cs_exp);
      check(port_we_n == we_exp, "R4", $sformatf("we_n count %0d", c), port_we_n, we_exp);
      check(port_data == d_exp, "R5", $sformatf("data count %0d", c), port_data, d_exp);
      check(in_ready == (c == int'(t.last)), "R6", $sformatf("ready count %0d", c),
            in_ready, (c == int'(t.last)));
      @(negedge clk);
    end
    bus_prev = w;
  endtask

  task automatic send(input logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    watch(w, 1'b0, 16'h0);
  endtask

  task automatic t_reset;
    check(port_cs_n === 1'b1 && port_we_n === 1'b1, "R1", "strobes after reset",
          {port_cs_n, port_we_n}, 2'b11);
    check(port_data === 16'h0, "R1", "data after reset", port_data, 0);
    check(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);
  endtask

  task automatic t_default;
    send(16'hA5C3);
  endtask

  task automatic t_idle_hold;
    for (int i = 0; i < 5; i++) begin
      check(port_cs_n && port_we_n && in_ready && port_data == bus_prev, "R8",
            "idle state", {port_cs_n, port_we_n, in_ready, port_data},
            {3'b111, bus_prev});
      @(negedge clk);
    end
  endtask

  task automatic t_no_addr;
    load_cfg(mk(0, 1, 0, 0, 1, 2));
    check(cur.last == 2, "R10", "zero-start set kept", cur.last, 2);
    send(16'h1234);
  endtask

  task automatic t_wide;
    load_cfg(mk(2, 10, 3, 5, 9, 12));
    send(16'hBEEF);
  endtask

  task automatic t_reject;
    wtime_t keep = cur;
    load_cfg(mk(0, 9, 6, 5, 9, 12));   // data_on after we_on
    load_cfg(mk(2, 8, 3, 5, 9, 12));   // cs_off before we_off
    load_cfg(mk(2, 9, 3, 5, 9, 9));    // no hold after strobe rise
    check(cur == keep, "R9", "bench model kept set", 0, 0);
    send(16'h0F0F);
  endtask

  task automatic t_burst;
    int t0;
    load_cfg(mk(0, 2, 0, 1, 2, 3));
    in_valid = 1'b1;
    in_data  = 16'h1111;
    @(negedge clk);
    t0 = cyc;
    watch(16'h1111, 1'b1, 16'h2222);
    watch(16'h2222, 1'b1, 16'h3333);
    watch(16'h3333, 1'b0, 16'h0);
    check(cyc - t0 == 3 * 4, "R7", "clocks for three words", cyc - t0, 12);
  endtask

  initial begin
    cur = mk(0, 3, 0, 1, 3, 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_idle_hold();
    t_no_addr();
    t_wide();
    t_reject();
    t_burst();
    t_idle_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule